// File: doc/BRIEF.md
# Keyed Software Watchdog

This block is a software watchdog. It leaves reset already running and counts watchdog clocks. If software does not restart it in time, it raises either a system reset request or a top-priority interrupt request. Software restarts the count by writing a two-byte key to a service location: first 0x55, then 0xAA. Any amount of other bus traffic may fall between the two key writes.

A small write-only register bus carries all programming. There are three locations:
- a settings location, which takes exactly one write after reset;
- the service location that takes the key;
- a vector location, whose byte is presented alongside the interrupt request.

The period is set by two things. An optional divide-by-2^PRE_BITS prescaler comes first. A selectable tap on a binary divider chain follows it. The watchdog clock is frozen while a low-power stop input or a debug freeze input is high.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the outputs `rst_req` and `irq_req` are low and `irq_vec` is 0x0F. The watchdog runs enabled, in reset mode, with no prescaler and tap 0. Without any bus write, `rst_req` pulses on the 2^TAP_BASE-th clock edge after reset release.
- R2: The settings location (address 0) is written as follows: bit 0 enables the watchdog, bit 1 picks interrupt mode (1) or reset mode (0), bit 2 enables the prescaler, and bits 4:3 pick the tap. Only the first write after reset takes effect, and every later write to it is ignored until the next reset.
- R3: A write of 0x55 to the service location (address 1) arms the key. A following write of 0xAA there clears the prescaler and the divider. The next timeout then falls exactly one full period after the clock edge of the 0xAA write.
- R4: A 0xAA written to the service location while the key is not armed does nothing. While armed, other values written there, further 0x55 writes, and writes to other addresses all leave the key armed.
- R5: With the prescaler off, the period is 2^(TAP_BASE + TAP_STEP*tap) clocks, which is 2^9, 2^11, 2^13 or 2^15 with default parameters.
- R6: With the prescaler on, the period from R5 is multiplied by 2^PRE_BITS.
- R7: A timeout produces a one-clock pulse. The pulse appears on `rst_req` in reset mode and on `irq_req` in interrupt mode, and never on both at once.
- R8: After a timeout the count restarts from zero. Without service, another timeout follows one period later.
- R9: `irq_vec` always shows the last byte written to the vector location (address 2).
- R10: While `lp_stop` or `dbg_freeze` is high, the count holds and no timeout occurs. Each held clock delays the timeout by one clock.
- R11: When the enable bit is cleared, neither request ever pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, one write per clock |
| bus_addr | input | 2 | Register address: 0 settings, 1 service key, 2 vector |
| bus_wdata | input | 8 | Write data |
| lp_stop | input | 1 | Low-power stop; holds the watchdog clock |
| dbg_freeze | input | 1 | Debug freeze; holds the watchdog clock |
| rst_req | output | 1 | One-clock system reset request on timeout |
| irq_req | output | 1 | One-clock highest-priority interrupt request on timeout |
| irq_vec | output | 8 | Programmed interrupt vector |

## Verification
Several properties are checked on every cycle:
- the settings stay constant once they are locked;
- an armed key stays armed through any non-0xAA service write;
- the divider is zero right after a service;
- the count does not move while held or disabled;
- the two requests are exclusive one-clock pulses.

The exact timing of the period can only be shown by the bench's scenarios. This covers each tap with and without the prescaler, the one-period offset after the 0xAA write, the repeat in interrupt mode, and the delay added by stop and freeze. Whether later settings writes really have no effect is also shown there, by observing request timing.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int SEL_W    = 2;
    localparam int NUM_TAPS = 1 << SEL_W;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_KEY = 2'd1;
    localparam logic [1:0] ADDR_VEC = 2'd2;

    localparam logic [7:0] KEY_ARM   = 8'h55;
    localparam logic [7:0] KEY_FIRE  = 8'hAA;
    localparam logic [7:0] VEC_RESET = 8'h0F;

    // packed with enable at bit 0, tap select at the top
    typedef struct packed {
        logic [SEL_W-1:0] tsel;
        logic             pre_en;
        logic             irq_mode;
        logic             enable;
    } wd_cfg_t;

    localparam wd_cfg_t CFG_RESET = '{tsel: '0, pre_en: 1'b0, irq_mode: 1'b0, enable: 1'b1};

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output wd_cfg_t    cfg_o,
    output logic [7:0] vec_o
);
    localparam int CFG_W = $bits(wd_cfg_t);

    typedef struct packed {
        wd_cfg_t    cfg;
        logic       locked;
        logic [7:0] vec;
    } regs_t;

    regs_t regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr && bus_addr == ADDR_CFG && !regs_q.locked) begin
            regs_d.cfg    = wd_cfg_t'(bus_wdata[CFG_W-1:0]);
            regs_d.locked = 1'b1;
        end
        if (bus_wr && bus_addr == ADDR_VEC) begin
            regs_d.vec = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{cfg: CFG_RESET, locked: 1'b0, vec: VEC_RESET};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg_o = regs_q.cfg;
    assign vec_o = regs_q.vec;

    // R2: once locked, settings never change until reset
    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.locked |=> $stable(regs_q.cfg));

    // R9: a vector write lands on the output the next cycle
    a_r9_vec_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_VEC) |=> (vec_o == $past(bus_wdata)));
endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       svc_o
);
    typedef struct packed {
        key_state_e st;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        if (key_wr) begin
            case (seq_q.st)
                KEY_IDLE: begin
                    if (key_data == KEY_ARM) seq_d.st = KEY_ARMED;
                end
                KEY_ARMED: begin
                    if (key_data == KEY_FIRE) seq_d.st = KEY_IDLE;
                end
                default: seq_d.st = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: KEY_IDLE};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign svc_o = key_wr && (seq_q.st == KEY_ARMED) && (key_data == KEY_FIRE);

    // R4: any non-fire write keeps the armed state
    a_r4_stay_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == KEY_ARMED && !(key_wr && key_data == KEY_FIRE)) |=> (seq_q.st == KEY_ARMED));

    // R4: a fire byte while idle does not service
    a_r4_idle_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == KEY_IDLE) |-> !svc_o);

    // R3: a completed key returns to idle
    a_r3_key_done: assert property (@(posedge clk) disable iff (!rst_n)
        svc_o |=> (seq_q.st == KEY_IDLE));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int PRE_BITS = 9,
    parameter int TAP_BASE = 9,
    parameter int TAP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             hold_i,
    input  logic             pre_en_i,
    input  logic [SEL_W-1:0] tsel_i,
    input  logic             clr_i,
    output logic             timeout_o
);
    localparam int DIV_W = TAP_BASE + TAP_STEP * (NUM_TAPS - 1);

    typedef struct packed {
        logic [PRE_BITS-1:0] pre;
        logic [DIV_W-1:0]    div;
        logic                to;
    } cnt_t;

    cnt_t cnt_q, cnt_d;
    logic [NUM_TAPS-1:0] tap_hit;

    // one terminal-count comparator per selectable tap
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam logic [63:0] LIM64 = (64'd1 << (TAP_BASE + TAP_STEP * g)) - 64'd1;
        localparam logic [DIV_W-1:0] LIM = LIM64[DIV_W-1:0];
        assign tap_hit[g] = (cnt_q.div >= LIM);
    end

    always_comb begin
        logic run;
        logic tick;
        cnt_d    = cnt_q;
        cnt_d.to = 1'b0;
        run      = enable_i && !hold_i;
        tick     = !pre_en_i || (&cnt_q.pre);
        if (clr_i) begin
            cnt_d.pre = '0;
            cnt_d.div = '0;
        end else if (run) begin
            if (pre_en_i) cnt_d.pre = cnt_q.pre + PRE_BITS'(1);
            if (tick) begin
                if (tap_hit[tsel_i]) begin
                    cnt_d.div = '0;
                    cnt_d.to  = 1'b1;
                end else begin
                    cnt_d.div = cnt_q.div + DIV_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '{pre: '0, div: '0, to: 1'b0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign timeout_o = cnt_q.to;

    // R3: service zeroes prescaler and divider
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q.div == '0 && cnt_q.pre == '0));

    // R10: held clock freezes the count and blocks timeouts
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clr_i) |=> ($stable(cnt_q.div) && !cnt_q.to));

    // R11: disabled watchdog never times out
    a_r11_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !clr_i) |=> ($stable(cnt_q.div) && !cnt_q.to));

    // R8: the divider restarts from zero at each timeout
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.to |-> (cnt_q.div == '0));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int PRE_BITS = 9,
    parameter int TAP_BASE = 9,
    parameter int TAP_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       lp_stop,
    input  logic       dbg_freeze,
    output logic       rst_req,
    output logic       irq_req,
    output logic [7:0] irq_vec
);
    wd_cfg_t cfg;
    logic    svc;
    logic    timeout;

    kwd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg_o     (cfg),
        .vec_o     (irq_vec)
    );

    kwd_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (bus_wr && bus_addr == ADDR_KEY),
        .key_data (bus_wdata),
        .svc_o    (svc)
    );

    kwd_counter #(
        .PRE_BITS (PRE_BITS),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (cfg.enable),
        .hold_i    (lp_stop || dbg_freeze),
        .pre_en_i  (cfg.pre_en),
        .tsel_i    (cfg.tsel),
        .clr_i     (svc),
        .timeout_o (timeout)
    );

    assign rst_req = timeout && !cfg.irq_mode;
    assign irq_req = timeout && cfg.irq_mode;

    // R7: requests are exclusive single-cycle pulses
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req, irq_req}));

    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || irq_req) |=> !(rst_req || irq_req));
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PB = 2;
    localparam int TB = 3;
    localparam int TS = 2;
    localparam int MAX_CYC = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       lp_stop = 1'b0;
    logic       dbg_freeze = 1'b0;
    logic       rst_req, irq_req;
    logic [7:0] irq_vec;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    int rst_cnt = 0, irq_cnt = 0, rst_at = -1, irq_at = -1;
    int rel = 0;
    bit done = 1'b0;

    keyed_watchdog #(.PRE_BITS(PB), .TAP_BASE(TB), .TAP_STEP(TS)) u_keyed_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .lp_stop    (lp_stop),
        .dbg_freeze (dbg_freeze),
        .rst_req    (rst_req),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_req === 1'b1) begin rst_cnt++; rst_at = cyc; end
        if (irq_req === 1'b1) begin irq_cnt++; irq_at = cyc; end
    end

    always @(posedge clk) begin
        if (cyc > MAX_CYC && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all): actual cycle %0d expected below %0d", cyc, MAX_CYC);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // stimulus table: settings byte, expected period after key, interrupt mode
    typedef struct packed {
        logic [7:0]  cfg;
        logic [15:0] period;
        logic        irq;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{8'h01, 16'd8,    1'b0},   // tap0, reset
        '{8'h09, 16'd32,   1'b0},   // tap1, reset
        '{8'h13, 16'd128,  1'b1},   // tap2, interrupt
        '{8'h19, 16'd512,  1'b0},   // tap3, reset
        '{8'h07, 16'd32,   1'b1},   // tap0 + prescaler, interrupt
        '{8'h1D, 16'd2048, 1'b0}    // tap3 + prescaler, reset
    };

    task automatic chk(input string req, input int act, input int exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        #1;
        rst_cnt = 0; irq_cnt = 0; rst_at = -1; irq_at = -1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, output int stamp);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        stamp = cyc + 1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lp_stop = 1'b0; dbg_freeze = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rel = cyc;
        #1;
        rst_cnt = 0; irq_cnt = 0; rst_at = -1; irq_at = -1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int s;
        int a;

        // R1: reset state while reset is held
        wait_cyc(2);
        chk("R1 rst_req in reset", int'(rst_req), 0);
        chk("R1 irq_req in reset", int'(irq_req), 0);
        chk("R1 irq_vec in reset", int'(irq_vec), 'h0F);

        // table walk: each setting with key service, measured from the 0xAA edge
        for (int i = 0; i < 6; i++) begin
            do_reset();
            bus_write(2'd0, TBL[i].cfg, s);
            bus_write(2'd2, 8'hA0 + 8'(i), s);
            bus_write(2'd1, 8'h55, s);
            #1;
            rst_cnt = 0; irq_cnt = 0; rst_at = -1; irq_at = -1;
            bus_write(2'd1, 8'hAA, a);
            wait_cyc(int'(TBL[i].period) + 3);
            if (TBL[i].irq) begin
                chk("R5/R6/R7 irq pulse count", irq_cnt, 1);
                chk("R3/R5/R6 irq timing", irq_at, a + int'(TBL[i].period));
                chk("R7 no reset in irq mode", rst_cnt, 0);
                chk("R9 vector", int'(irq_vec), 'hA0 + i);
            end else begin
                chk("R5/R6/R7 reset pulse count", rst_cnt, 1);
                chk("R3/R5/R6 reset timing", rst_at, a + int'(TBL[i].period));
                chk("R7 no irq in reset mode", irq_cnt, 0);
            end
        end

        // R1: default timeout with no writes
        do_reset();
        wait_cyc(12);
        chk("R1 default pulse count", rst_cnt, 1);
        chk("R1 default timing", rst_at, rel + 8);

        // R4: lone 0xAA while idle is ignored
        do_reset();
        bus_write(2'd1, 8'hAA, s);
        bus_write(2'd1, 8'h12, s);
        wait_cyc(8);
        chk("R4 idle AA ignored timing", rst_at, rel + 8);
        chk("R4 idle AA ignored count", rst_cnt, 1);

        // R4: traffic between the key bytes keeps the key armed
        do_reset();
        bus_write(2'd1, 8'h55, s);
        bus_write(2'd1, 8'h33, s);
        bus_write(2'd2, 8'hAA, s);
        bus_write(2'd1, 8'h55, s);
        bus_write(2'd1, 8'hAA, a);
        wait_cyc(10);
        chk("R4 armed across traffic count", rst_cnt, 1);
        chk("R4 armed across traffic timing", rst_at, a + 8);
        chk("R9 vector from write", int'(irq_vec), 'hAA);

        // R2/R11: disabled on first write, re-enable attempt ignored
        do_reset();
        bus_write(2'd0, 8'h00, s);
        bus_write(2'd0, 8'h01, s);
        wait_cyc(600);
        chk("R11 no reset when disabled", rst_cnt, 0);
        chk("R2 re-enable ignored", irq_cnt, 0);

        // R2: second settings write cannot change tap or mode
        do_reset();
        bus_write(2'd0, 8'h01, s);
        bus_write(2'd0, 8'h1B, s);
        bus_write(2'd1, 8'h55, s);
        bus_write(2'd1, 8'hAA, a);
        wait_cyc(12);
        chk("R2 locked mode stays reset", irq_cnt, 0);
        chk("R2 locked tap timing", rst_at, a + 8);

        // R8: interrupt mode repeats without service
        do_reset();
        bus_write(2'd0, 8'h03, s);
        bus_write(2'd2, 8'h5C, s);
        bus_write(2'd1, 8'h55, s);
        #1;
        rst_cnt = 0; irq_cnt = 0;
        bus_write(2'd1, 8'hAA, a);
        wait_cyc(20);
        chk("R8 repeat count", irq_cnt, 2);
        chk("R8 repeat timing", irq_at, a + 16);
        chk("R7 no reset in repeat", rst_cnt, 0);
        chk("R9 vector 5C", int'(irq_vec), 'h5C);

        // R10: freeze for five clocks delays timeout by five
        do_reset();
        bus_write(2'd1, 8'h55, s);
        bus_write(2'd1, 8'hAA, a);
        @(negedge clk);
        dbg_freeze = 1'b1;
        wait_cyc(5);
        dbg_freeze = 1'b0;
        wait_cyc(12);
        chk("R10 freeze timing", rst_at, a + 13);
        chk("R10 freeze count", rst_cnt, 1);

        // R10: stop for three clocks delays timeout by three
        do_reset();
        bus_write(2'd1, 8'h55, s);
        bus_write(2'd1, 8'hAA, a);
        @(negedge clk);
        lp_stop = 1'b1;
        wait_cyc(3);
        lp_stop = 1'b0;
        wait_cyc(12);
        chk("R10 stop timing", rst_at, a + 11);

        clear_counts();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule